// File: doc/BRIEF.md
# MIDI Host Port Controller (pass-through UART mode)

This block sits between a host processor and a MIDI byte link. The host reaches it through a window of two byte-wide addresses. One address carries data in both directions. The other reads back a status byte and accepts command bytes on writes. Serial bit timing is out of scope: outgoing and incoming MIDI bytes travel as simple valid/ready byte streams.

The block holds a one-byte response slot and a mode flag. After reset it sits in command mode. In that mode every command is acknowledged with the byte 0xFE, and host data writes are discarded. The enter-pass-through command switches it to UART mode. In UART mode host data writes go straight to the transmit stream, and data reads return received bytes. Only the reset command is still honoured; it returns the block to command mode and queues an acknowledge.

Acknowledge bytes and received MIDI bytes share the data port. A pending acknowledge is always returned first.

Top module: `midi_host_port`

## Requirements
- R1: After reset, rd_data is 0x00, the block is in command mode and no response is pending. A status read then returns 0x80.
- R2: Read offset 0 is the data port and read offset 1 is status. Write offset 0 is the data port and write offset 1 is the command port.
- R3: In the status byte, bit 7 is 1 when no byte is available and bit 6 is 1 when the block cannot accept a byte. Bits 5..0 are always 0.
- R4: Command 0xFF, in either mode, selects command mode, discards any pending response and leaves 0xFE pending.
- R5: Command 0x3F in command mode selects UART mode and leaves 0xFE pending.
- R6: Any other command value queues 0xFE in command mode. In UART mode it changes nothing: no response and no mode change.
- R7: A data-port write raises tx_valid with tx_data equal to the written byte in that same cycle, but only in UART mode. In command mode tx_valid stays low.
- R8: A data read returns the pending response and clears it. With no response pending, in UART mode with rx_valid high, it returns rx_data and pulses rx_ready in that cycle. In every other case it returns 0xFE. rx_ready is never high otherwise.
- R9: Output-ready (status bit 6 clear) always holds in command mode. In UART mode it follows tx_ready. Input-available means a response is pending, or UART mode with rx_valid high.
- R10: rd_data is registered: it changes on the clock edge that ends a read strobe and holds while there is no read. Status reads change no state.
- R11: A data read and a command write in the same cycle are handled read first. The read sees the state from before the command, and any response the command queues stays pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_addr | input | 1 | Read offset (0 data, 1 status) |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 1 | Write offset (0 data, 1 command) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| tx_data | output | 8 | Outgoing MIDI byte |
| tx_valid | output | 1 | Outgoing byte offered |
| tx_ready | input | 1 | Transmit side can take a byte |
| rx_data | input | 8 | Incoming MIDI byte |
| rx_valid | input | 1 | Incoming byte waiting |
| rx_ready | output | 1 | Pop the incoming byte |

## Verification
A directed sequence first walks both modes. It issues the reset, pass-through and unknown commands in each mode, so that mode-dependent acknowledges can be told apart from ignored commands. Data reads are tried in three situations: with a response pending, with only a received byte waiting, and with neither. These separate the priority between the response and the received byte, and show the 0xFE fallback. A same-cycle data read plus command write checks the read-first ordering. A long random phase then mixes all strobes with toggling tx_ready and rx_valid. A behavioural model is compared with the design on every clock.

// File: rtl/mhp_pkg.sv
package mhp_pkg;
  localparam int BYTE_W   = 8;
  localparam int BIT_NOIN = BYTE_W - 1;  // status: nothing to read
  localparam int BIT_BUSY = BYTE_W - 2;  // status: cannot accept

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CODE_RESET = 8'hFF;
  localparam byte_t CODE_PASS  = 8'h3F;
  localparam byte_t CODE_ACK   = 8'hFE;

  typedef struct packed {
    logic data_rd;
    logic stat_rd;
    logic data_wr;
    logic cmd_wr;
  } bus_ev_t;

  // Status byte from the current state and stream flags.
  function automatic byte_t f_status(logic uart, logic resp_v, logic rx_v, logic tx_r);
    byte_t s;
    s = '0;
    s[BIT_NOIN] = ~(resp_v | (uart & rx_v));
    s[BIT_BUSY] = ~(~uart | tx_r);
    return s;
  endfunction

  // Whether a command byte is answered with an acknowledge.
  function automatic logic f_cmd_acks(logic uart, byte_t code);
    return (code == CODE_RESET) | ~uart;
  endfunction

  // Mode after a command byte.
  function automatic logic f_cmd_mode(logic uart, byte_t code);
    logic m;
    m = uart;
    if (code == CODE_RESET)  m = 1'b0;
    else if (code == CODE_PASS) m = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mhp_decode.sv
module mhp_decode
  import mhp_pkg::*;
(
  input  logic    rd_en,
  input  logic    rd_addr,
  input  logic    wr_en,
  input  logic    wr_addr,
  output bus_ev_t ev
);
  // R2: offset 0 is data, offset 1 is status (read) / command (write)
  always_comb begin
    ev.data_rd = rd_en & ~rd_addr;
    ev.stat_rd = rd_en &  rd_addr;
    ev.data_wr = wr_en & ~wr_addr;
    ev.cmd_wr  = wr_en &  wr_addr;
  end
endmodule

// File: rtl/mhp_ctrl.sv
module mhp_ctrl
  import mhp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_ev_t ev,
  input  byte_t   wr_data,
  input  logic    resp_taken,
  output logic    uart_mode,
  output logic    resp_valid,
  output byte_t   resp_byte,
  output logic    tx_valid,
  output byte_t   tx_data,
  output logic    ev_ack_load
);
  logic  uart_nx;
  logic  resp_v_nx;
  byte_t resp_b_nx;

  assign ev_ack_load = ev.cmd_wr & f_cmd_acks(uart_mode, wr_data);

  always_comb begin
    // the read is handled first, then the command (R11)
    uart_nx   = uart_mode;
    resp_v_nx = resp_valid & ~resp_taken;
    resp_b_nx = resp_byte;
    if (ev.cmd_wr) begin
      uart_nx = uart_mode ? ((wr_data == CODE_RESET) ? 1'b0 : 1'b1)
                          : f_cmd_mode(1'b0, wr_data);
    end
    if (ev_ack_load) begin
      resp_v_nx = 1'b1;
      resp_b_nx = CODE_ACK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uart_mode  <= 1'b0;
      resp_valid <= 1'b0;
      resp_byte  <= '0;
    end else begin
      uart_mode  <= uart_nx;
      resp_valid <= resp_v_nx;
      resp_byte  <= resp_b_nx;
    end
  end

  // R7: data writes go to the transmit stream only in UART mode
  assign tx_valid = ev.data_wr & uart_mode;
  assign tx_data  = wr_data;

  a_r4_reset_acks: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cmd_wr && wr_data == CODE_RESET |=> !uart_mode && resp_valid && resp_byte == CODE_ACK);
  a_r5_enter_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cmd_wr && !uart_mode && wr_data == CODE_PASS |=> uart_mode && resp_valid);
  a_r6_uart_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cmd_wr && uart_mode && wr_data != CODE_RESET && !ev.data_rd |=> uart_mode && $stable(resp_valid));
  a_r7_tx_only_uart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> uart_mode);
  a_r10_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev.stat_rd && !ev.cmd_wr |=> $stable(uart_mode) && $stable(resp_valid));
  a_r11_ack_survives: assert property (@(posedge clk) disable iff (!rst_n)
    ev.data_rd && ev_ack_load |=> resp_valid);
endmodule

// File: rtl/mhp_rdpath.sv
module mhp_rdpath
  import mhp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bus_ev_t ev,
  input  logic    uart_mode,
  input  logic    resp_valid,
  input  byte_t   resp_byte,
  input  logic    rx_valid,
  input  byte_t   rx_data,
  input  logic    tx_ready,
  output byte_t   rd_data,
  output logic    rx_ready,
  output logic    resp_taken
);
  logic  ev_pop;
  byte_t data_sel;

  // R8: response first, then a received byte in UART mode, else the ack code
  assign resp_taken = ev.data_rd & resp_valid;
  assign ev_pop     = ev.data_rd & ~resp_valid & uart_mode & rx_valid;
  assign rx_ready   = ev_pop;

  always_comb begin
    if (resp_valid)  data_sel = resp_byte;
    else if (ev_pop) data_sel = rx_data;
    else             data_sel = CODE_ACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data <= '0;
    else if (ev.data_rd) rd_data <= data_sel;
    else if (ev.stat_rd) rd_data <= f_status(uart_mode, resp_valid, rx_valid, tx_ready);
  end

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev.stat_rd |=> rd_data[BIT_BUSY-1:0] == '0);
  a_r8_pop_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid && !resp_taken);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.data_rd && !ev.stat_rd |=> $stable(rd_data));
  a_r8_resp_returned: assert property (@(posedge clk) disable iff (!rst_n)
    resp_taken |=> rd_data == $past(resp_byte));
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
  import mhp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       rd_addr,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready
);
  bus_ev_t ev;
  logic    uart_mode;
  logic    resp_valid;
  byte_t   resp_byte;
  logic    resp_taken;
  logic    ev_ack_load;

  mhp_decode u_decode (
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .ev(ev)
  );

  mhp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wr_data(wr_data), .resp_taken(resp_taken),
    .uart_mode(uart_mode), .resp_valid(resp_valid), .resp_byte(resp_byte),
    .tx_valid(tx_valid), .tx_data(tx_data), .ev_ack_load(ev_ack_load)
  );

  mhp_rdpath u_rdpath (
    .clk(clk), .rst_n(rst_n), .ev(ev), .uart_mode(uart_mode),
    .resp_valid(resp_valid), .resp_byte(resp_byte),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
    .rd_data(rd_data), .rx_ready(rx_ready), .resp_taken(resp_taken)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !uart_mode && !resp_valid && rd_data == 8'h00);
  a_r9_cmd_mode_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_mode |-> !tx_valid && !rx_ready);
endmodule

// File: tb/midi_host_port_tb_top.sv
module midi_host_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 0, rd_addr = 0, wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0, rx_data = 0;
  logic tx_ready = 1, rx_valid = 0;
  logic [7:0] rd_data, tx_data;
  logic tx_valid, rx_ready;

  always #5 clk = ~clk;

  midi_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model
  bit     m_uart = 0, m_pend = 0;
  integer m_rdata = 0;
  string  prev_tag = "R1";

  task automatic chk(string tag, integer act, integer exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check, then advance the model at posedge.
  task automatic op(bit rd, bit ra, bit wr, bit wa, integer wd, bit txr, bit rxv, integer rxd, string tag);
    bit exp_txv, exp_pop;
    integer nxt_rd;
    @(negedge clk);
    rd_en = rd; rd_addr = ra; wr_en = wr; wr_addr = wa; wr_data = wd[7:0];
    tx_ready = txr; rx_valid = rxv; rx_data = rxd[7:0];
    #1;
    exp_txv = wr && !wa && m_uart;
    exp_pop = rd && !ra && !m_pend && m_uart && rxv;
    chk(prev_tag, rd_data, m_rdata, "rd_data");
    chk(tag, tx_valid, exp_txv, "tx_valid");
    if (exp_txv) chk(tag, tx_data, wd, "tx_data");
    chk(tag, rx_ready, exp_pop, "rx_ready");
    nxt_rd = m_rdata;
    if (rd && !ra) begin
      if (m_pend) begin nxt_rd = 8'hFE; m_pend = 0; end
      else if (exp_pop) nxt_rd = rxd;
      else nxt_rd = 8'hFE;
    end else if (rd && ra) begin
      nxt_rd = ((m_pend || (m_uart && rxv)) ? 0 : 8'h80) | ((m_uart && !txr) ? 8'h40 : 0);
    end
    if (wr && wa) begin
      if (wd == 8'hFF) begin m_uart = 0; m_pend = 1; end
      else if (!m_uart) begin m_pend = 1; if (wd == 8'h3F) m_uart = 1; end
    end
    if (rd) prev_tag = tag;
    @(posedge clk);
    m_rdata = nxt_rd;
  endtask

  task automatic idle(string tag); op(0,0,0,0,0,1,0,0,tag); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1", rd_data, 8'h00, "reset rd_data");
    op(1,1,0,0,0,1,0,0,"R1");          // status after reset: 0x80
    idle("R1");
    op(1,0,0,0,0,1,1,8'h55,"R8");      // command mode, rx waiting: FE, no pop
    op(0,0,1,0,8'h12,1,0,0,"R7");      // data write in command mode dropped
    op(0,0,1,1,8'h12,1,0,0,"R6");      // unknown cmd in command mode: ack
    op(1,1,0,0,0,0,0,0,"R9");          // status: available, ready despite tx_ready=0
    op(1,0,0,0,0,1,0,0,"R6");          // returns ack
    op(1,0,0,0,0,1,0,0,"R8");          // nothing: FE
    op(0,0,1,1,8'h3F,1,0,0,"R5");      // enter UART mode
    op(1,0,0,0,0,1,1,8'h90,"R8");      // ack before rx byte, no pop
    op(1,1,0,0,0,0,0,0,"R9");          // status 0xC0
    op(1,1,0,0,0,1,1,8'h90,"R3");      // status 0x00
    op(1,0,0,0,0,1,1,8'h90,"R8");      // pop 0x90
    idle("R10");
    op(0,0,1,0,8'h45,1,0,0,"R7");      // tx 0x45
    op(0,0,1,1,8'h3F,1,0,0,"R6");      // ignored in UART
    op(0,0,1,1,8'h12,1,0,0,"R6");      // ignored in UART
    op(1,0,0,0,0,1,0,0,"R6");          // still no response: FE
    op(1,0,1,1,8'hFF,1,1,8'h7A,"R11"); // read pops 0x7A, then reset
    op(1,1,0,0,0,1,1,8'h11,"R4");      // command mode, ack pending: 0x00
    op(1,0,0,0,0,1,1,8'h11,"R4");      // ack
    op(0,0,1,0,8'h66,1,0,0,"R2");      // dropped again
    op(0,0,1,1,8'hFF,1,0,0,"R4");      // reset in command mode
    op(1,0,0,0,0,1,0,0,"R4");
    for (int i = 0; i < 3000; i++) begin
      int k; integer c;
      k = $urandom_range(0, 9);
      c = (k == 0) ? 8'hFF : (k < 3) ? 8'h3F : $urandom_range(0, 255);
      op($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,2) == 0,
         $urandom_range(0,1), c, $urandom_range(0,1), $urandom_range(0,1),
         $urandom_range(0,255), "R10");
    end
    idle("R10");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule